// File: doc/BRIEF.md
# Sound RAM DMA Port with Interrupt-Address Watch

This block moves blocks of 16-bit halfwords between a host DMA channel and a 512 KiB sound RAM. Software first sets the current transfer address. A start pulse then gives a direction and a halfword count. Each beat moves one halfword and advances the address by two bytes. The address wraps inside the 512 KiB space and always stays halfword-aligned. Write beats arrive on a valid/ready stream from the host. Read beats return on a second valid/ready stream. The sound RAM is outside the block and is reached through a simple single-port interface with a one-cycle read latency.

When a transfer starts, the block checks whether a programmable interrupt address falls inside the span the transfer covers. The interrupt register counts in 8-byte units. If the address is inside the span and interrupts are enabled, a sticky flag is raised. A write that runs past the top of RAM also counts the part that wrapped back to address zero. A read does not.

A busy output stays high for a time that grows with the transfer length. While busy is high, a new start is ignored. A sticky dirty flag records that a write transfer has been accepted.

Top module: `srd_dma_port`

## Requirements
- R1: A start that arrives while `busy` is high is ignored: the address does not move, the RAM is not accessed and the busy time is not extended.
- R2: Each beat moves exactly one halfword and adds 2 to `xfer_addr`. `ram_addr` is `xfer_addr` divided by two (its bits 18 down to 1).
- R3: The address wraps from 0x7FFFE to 0x00000. Loading the address through `xfer_addr_wr` clears bit 0.
- R4: When a transfer of n halfwords from address A ends, `xfer_addr` equals (A + 2n) mod 0x80000.
- R5: With the watch address W = `irq_addr_reg` × 8, a transfer hits when A ≤ W < A + 2n. This sum is taken without wrap.
- R6: A write with A + 2n ≥ 0x80000 also hits when W < ((A + 2n) & 0x7FFFF). A read never hits through this wrapped part.
- R7: `irq_flag` is set only by a hit on an accepted start while `irq_enable` is 1 in that cycle. It then stays set until `irq_ack`.
- R8: After an accepted start with count n, `busy` stays high for exactly 20·n + 1 cycles, provided the host keeps pace with the beats.
- R9: A count of zero makes no RAM access, leaves the address unchanged, raises no interrupt and holds `busy` high for exactly one cycle.
- R10: `mem_dirty` is set by an accepted write start, including one with a count of zero. A read does not set it. `dirty_ack` clears it.
- R11: A read beat presents `rd_valid` with `rd_data` and holds both steady until `rd_ready` is seen. The data is the RAM word at the current address.
- R12: After reset, `xfer_addr` is 0 and `busy`, `irq_flag`, `mem_dirty`, `wr_ready` and `rd_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_addr_wr | input | 1 | Load the transfer address; honoured only when idle and no start is present |
| xfer_addr_in | input | 19 | Byte address to load |
| xfer_addr | output | 19 | Current transfer byte address |
| irq_addr_reg | input | 16 | Watch address in 8-byte units |
| irq_enable | input | 1 | Allows an interrupt to be flagged |
| irq_ack | input | 1 | Clears `irq_flag` |
| irq_flag | output | 1 | Sticky interrupt flag |
| dirty_ack | input | 1 | Clears `mem_dirty` |
| mem_dirty | output | 1 | Sticky flag: sound RAM was written |
| start | input | 1 | Start pulse for a transfer |
| dir_write | input | 1 | 1 = host to RAM, 0 = RAM to host |
| count | input | 16 | Number of halfwords to move |
| busy | output | 1 | Transfer or busy time still running |
| wr_valid | input | 1 | Host write data is valid |
| wr_data | input | 16 | Host write halfword |
| wr_ready | output | 1 | Block accepts a write halfword |
| rd_valid | output | 1 | Read halfword available |
| rd_data | output | 16 | Read halfword |
| rd_ready | input | 1 | Host takes the read halfword |
| ram_addr | output | 18 | Sound RAM halfword index |
| ram_we | output | 1 | Sound RAM write strobe |
| ram_wdata | output | 16 | Sound RAM write data |
| ram_re | output | 1 | Sound RAM read strobe |
| ram_rdata | input | 16 | Sound RAM read data, valid one cycle after `ram_re` |

## Verification
The assertions rely on a few properties of the inputs. The sound RAM must return data exactly one cycle after `ram_re`. The host must hold `rd_ready` low until it has seen `rd_valid`. The busy-time check also assumes the host does not stall a transfer past the end of the timer. The stimulus drives every input at the falling edge. The RAM model has a fixed one-cycle read latency. Each write halfword is offered as soon as `wr_ready` rises, and each read beat is accepted within two cycles of `rd_valid`. Every transfer therefore ends well inside its busy window of 20·n + 1 cycles.

// File: rtl/srd_pkg.sv
package srd_pkg;

   typedef enum logic [2:0] {
      SRD_IDLE,
      SRD_WR,
      SRD_RD_REQ,
      SRD_RD_CAP,
      SRD_RD_OUT
   } srd_state_e;

endpackage

// File: rtl/srd_addr_step.sv
module srd_addr_step #(
   parameter int BYTE_AW = 19
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [BYTE_AW-1:0] load_val,
   input  logic               step,
   output logic [BYTE_AW-1:0] addr
);

   localparam logic [BYTE_AW-1:0] ALIGN_MASK = {{(BYTE_AW-1){1'b1}}, 1'b0};
   localparam logic [BYTE_AW-1:0] STRIDE     = BYTE_AW'(2);

   // Natural overflow of the BYTE_AW-bit adder gives the wrap.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         addr <= '0;
      else if (load)
         addr <= load_val & ALIGN_MASK;
      else if (step)
         addr <= addr + STRIDE;
   end

   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (addr == $past(addr) + STRIDE));

   p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && addr == ALIGN_MASK) |=> (addr == '0));

endmodule

// File: rtl/srd_irq_window.sv
module srd_irq_window #(
   parameter int BYTE_AW   = 19,
   parameter int CNT_W     = 16,
   parameter int IRQ_W     = 16,
   parameter int IRQ_SHIFT = 3,
   parameter bit READ_WRAP = 1'b0
) (
   input  logic [BYTE_AW-1:0] start_addr,
   input  logic [CNT_W-1:0]   count,
   input  logic [IRQ_W-1:0]   irq_reg,
   input  logic               is_write,
   output logic               hit
);

   localparam int IA_W  = IRQ_W + IRQ_SHIFT;
   localparam int SUM_W = ((BYTE_AW > CNT_W + 1) ? BYTE_AW : CNT_W + 1) + 1;

   logic [IA_W-1:0]  ia_raw;
   logic [SUM_W-1:0] s_addr, e_addr, ia, wrapped_end;
   logic             in_win, crossed, wrap_hit;

   assign ia_raw      = IA_W'(irq_reg) << IRQ_SHIFT;
   assign ia          = SUM_W'(ia_raw);
   assign s_addr      = SUM_W'(start_addr);
   assign e_addr      = s_addr + (SUM_W'(count) << 1);
   assign in_win      = (s_addr <= ia) && (ia < e_addr);
   assign crossed     = (e_addr >> BYTE_AW) != '0;
   assign wrapped_end = SUM_W'(e_addr[BYTE_AW-1:0]);

   generate
      if (READ_WRAP) begin : g_wrap_both
         assign wrap_hit = crossed && (ia < wrapped_end);
      end else begin : g_wrap_write
         assign wrap_hit = is_write && crossed && (ia < wrapped_end);
      end
   endgenerate

   assign hit = in_win || wrap_hit;

endmodule

// File: rtl/srd_busy_timer.sv
module srd_busy_timer #(
   parameter int CNT_W    = 16,
   parameter int BEAT_CYC = 20,
   parameter int TMR_W    = 22
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] count,
   output logic             active,
   output logic [TMR_W-1:0] cnt
);

   logic [TMR_W-1:0] load_val;

   // Bit 0 forced high: a zero-length transfer still reads busy for a cycle.
   assign load_val = (TMR_W'(count) * TMR_W'(BEAT_CYC)) | TMR_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - TMR_W'(1);
   end

   assign active = (cnt != '0);

   p_load_odd_r8: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt[0] && active));

endmodule

// File: rtl/srd_dma_port.sv
module srd_dma_port
   import srd_pkg::*;
#(
   parameter int BYTE_AW   = 19,
   parameter int CNT_W     = 16,
   parameter int DATA_W    = 16,
   parameter int IRQ_W     = 16,
   parameter int IRQ_SHIFT = 3,
   parameter int BEAT_CYC  = 20,
   parameter bit READ_WRAP = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               xfer_addr_wr,
   input  logic [BYTE_AW-1:0] xfer_addr_in,
   output logic [BYTE_AW-1:0] xfer_addr,
   input  logic [IRQ_W-1:0]   irq_addr_reg,
   input  logic               irq_enable,
   input  logic               irq_ack,
   output logic               irq_flag,
   input  logic               dirty_ack,
   output logic               mem_dirty,
   input  logic               start,
   input  logic               dir_write,
   input  logic [CNT_W-1:0]   count,
   output logic               busy,
   input  logic               wr_valid,
   input  logic [DATA_W-1:0]  wr_data,
   output logic               wr_ready,
   output logic               rd_valid,
   output logic [DATA_W-1:0]  rd_data,
   input  logic               rd_ready,
   output logic [BYTE_AW-2:0] ram_addr,
   output logic               ram_we,
   output logic [DATA_W-1:0]  ram_wdata,
   output logic               ram_re,
   input  logic [DATA_W-1:0]  ram_rdata
);

   localparam int TMR_W = CNT_W + $clog2(BEAT_CYC + 1) + 1;

   generate
      if (BYTE_AW < 2) begin : g_bad_aw
         $error("srd_dma_port: BYTE_AW must be at least 2");
      end
      if (IRQ_W + IRQ_SHIFT > BYTE_AW) begin : g_bad_irq
         $error("srd_dma_port: scaled watch address exceeds address width");
      end
      if (BEAT_CYC < 1) begin : g_bad_beat
         $error("srd_dma_port: BEAT_CYC must be at least 1");
      end
      if (CNT_W < 1 || DATA_W < 1) begin : g_bad_w
         $error("srd_dma_port: widths must be positive");
      end
   endgenerate

   srd_state_e        state_q, state_d;
   logic [CNT_W-1:0]  rem_q;
   logic [DATA_W-1:0] rd_data_q;
   logic [TMR_W-1:0]  tmr_cnt;
   logic              tmr_active;
   logic              start_ok, wr_beat, rd_beat, step, last_beat, addr_load, win_hit;

   assign busy      = tmr_active || (state_q != SRD_IDLE);
   assign start_ok  = start && !busy;
   assign wr_beat   = (state_q == SRD_WR) && wr_valid;
   assign rd_beat   = (state_q == SRD_RD_OUT) && rd_ready;
   assign step      = wr_beat || rd_beat;
   assign last_beat = (rem_q == CNT_W'(1));
   assign addr_load = xfer_addr_wr && !busy && !start;

   srd_addr_step #(.BYTE_AW(BYTE_AW)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (addr_load),
      .load_val (xfer_addr_in),
      .step     (step),
      .addr     (xfer_addr)
   );

   srd_irq_window #(
      .BYTE_AW   (BYTE_AW),
      .CNT_W     (CNT_W),
      .IRQ_W     (IRQ_W),
      .IRQ_SHIFT (IRQ_SHIFT),
      .READ_WRAP (READ_WRAP)
   ) u_win (
      .start_addr (xfer_addr),
      .count      (count),
      .irq_reg    (irq_addr_reg),
      .is_write   (dir_write),
      .hit        (win_hit)
   );

   srd_busy_timer #(
      .CNT_W    (CNT_W),
      .BEAT_CYC (BEAT_CYC),
      .TMR_W    (TMR_W)
   ) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (start_ok),
      .count  (count),
      .active (tmr_active),
      .cnt    (tmr_cnt)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SRD_IDLE: begin
            if (start_ok && count != '0)
               state_d = dir_write ? SRD_WR : SRD_RD_REQ;
         end
         SRD_WR: begin
            if (wr_beat && last_beat)
               state_d = SRD_IDLE;
         end
         SRD_RD_REQ: state_d = SRD_RD_CAP;
         SRD_RD_CAP: state_d = SRD_RD_OUT;
         SRD_RD_OUT: begin
            if (rd_beat)
               state_d = last_beat ? SRD_IDLE : SRD_RD_REQ;
         end
         default: state_d = SRD_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= SRD_IDLE;
         rem_q     <= '0;
         rd_data_q <= '0;
         irq_flag  <= 1'b0;
         mem_dirty <= 1'b0;
      end else begin
         state_q <= state_d;
         if (start_ok)
            rem_q <= count;
         else if (step)
            rem_q <= rem_q - CNT_W'(1);
         if (state_q == SRD_RD_CAP)
            rd_data_q <= ram_rdata;
         if (start_ok && win_hit && irq_enable)
            irq_flag <= 1'b1;
         else if (irq_ack)
            irq_flag <= 1'b0;
         if (start_ok && dir_write)
            mem_dirty <= 1'b1;
         else if (dirty_ack)
            mem_dirty <= 1'b0;
      end
   end

   assign wr_ready  = (state_q == SRD_WR);
   assign rd_valid  = (state_q == SRD_RD_OUT);
   assign rd_data   = rd_data_q;
   assign ram_addr  = xfer_addr[BYTE_AW-1:1];
   assign ram_we    = wr_beat;
   assign ram_wdata = wr_data;
   assign ram_re    = (state_q == SRD_RD_REQ);

   p_start_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy && tmr_cnt > TMR_W'(1)) |=> (tmr_cnt == $past(tmr_cnt) - TMR_W'(1)));

   p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_flag) |-> $past(start && !busy && irq_enable));

   p_zero_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && count == '0) |=> (!ram_we && !ram_re && $stable(xfer_addr)));

   p_dirty_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_dirty) |-> $past(start && !busy && dir_write));

   p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

endmodule

// File: tb/tb_srd_dma_port.sv
module tb_srd_dma_port;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xfer_addr_wr = 1'b0;
   logic [18:0] xfer_addr_in = '0;
   logic [18:0] xfer_addr;
   logic [15:0] irq_addr_reg = '0;
   logic        irq_enable = 1'b0;
   logic        irq_ack = 1'b0;
   logic        irq_flag;
   logic        dirty_ack = 1'b0;
   logic        mem_dirty;
   logic        start = 1'b0;
   logic        dir_write = 1'b0;
   logic [15:0] count = '0;
   logic        busy;
   logic        wr_valid = 1'b0;
   logic [15:0] wr_data = '0;
   logic        wr_ready;
   logic        rd_valid;
   logic [15:0] rd_data;
   logic        rd_ready = 1'b0;
   logic [17:0] ram_addr;
   logic        ram_we;
   logic [15:0] ram_wdata;
   logic        ram_re;
   logic [15:0] ram_rdata = '0;

   int checks = 0;
   int errors = 0;
   int ram_ops = 0;
   bit finished = 0;

   logic [15:0] mem    [int];
   logic [15:0] shadow [int];

   always #5 clk = ~clk;

   srd_dma_port dut (
      .clk(clk), .rst_n(rst_n),
      .xfer_addr_wr(xfer_addr_wr), .xfer_addr_in(xfer_addr_in), .xfer_addr(xfer_addr),
      .irq_addr_reg(irq_addr_reg), .irq_enable(irq_enable), .irq_ack(irq_ack), .irq_flag(irq_flag),
      .dirty_ack(dirty_ack), .mem_dirty(mem_dirty),
      .start(start), .dir_write(dir_write), .count(count), .busy(busy),
      .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
      .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready),
      .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata),
      .ram_re(ram_re), .ram_rdata(ram_rdata)
   );

   // Sound RAM model: one-cycle read latency, holds read data between reads.
   always @(posedge clk) begin
      if (ram_we) begin
         mem[int'(ram_addr)] = ram_wdata;
         ram_ops++;
      end
      if (ram_re) begin
         ram_rdata <= mem.exists(int'(ram_addr)) ? mem[int'(ram_addr)] : 16'h0000;
         ram_ops++;
      end
   end

   typedef struct packed {
      logic        wr;
      logic [18:0] a;
      logic [15:0] n;
      logic [15:0] ireg;
      logic        en;
      logic        xirq;
      logic [18:0] xend;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 19'h00100, 16'd4, 16'h0020, 1'b1, 1'b1, 19'h00108},
      '{1'b1, 19'h00100, 16'd4, 16'h0021, 1'b1, 1'b0, 19'h00108},
      '{1'b0, 19'h00100, 16'd4, 16'h0020, 1'b0, 1'b0, 19'h00108},
      '{1'b1, 19'h7FFFC, 16'd4, 16'h0000, 1'b1, 1'b1, 19'h00004},
      '{1'b0, 19'h7FFFC, 16'd4, 16'h0000, 1'b1, 1'b0, 19'h00004},
      '{1'b0, 19'h7FFF8, 16'd2, 16'hFFFF, 1'b1, 1'b1, 19'h7FFFC},
      '{1'b1, 19'h7FFF0, 16'd8, 16'hFFFF, 1'b1, 1'b1, 19'h00000},
      '{1'b1, 19'h00200, 16'd1, 16'h0040, 1'b0, 1'b0, 19'h00202},
      '{1'b0, 19'h00100, 16'd1, 16'h0020, 1'b1, 1'b1, 19'h00102}
   };

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic load_addr(input logic [18:0] a);
      xfer_addr_in = a;
      xfer_addr_wr = 1'b1;
      @(negedge clk);
      xfer_addr_wr = 1'b0;
   endtask

   task automatic ack_irq();
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
   endtask

   task automatic ack_dirty();
      dirty_ack = 1'b1;
      @(negedge clk);
      dirty_ack = 1'b0;
   endtask

   task automatic fire(input logic wr, input logic [15:0] n);
      dir_write = wr;
      count     = n;
      start     = 1'b1;
      @(negedge clk);
      start     = 1'b0;
   endtask

   task automatic count_busy(output int k);
      k = 0;
      while (busy && k < 100000) begin
         k++;
         @(negedge clk);
      end
   endtask

   task automatic feed_writes(input logic [18:0] a, input int n, input logic [15:0] base);
      for (int i = 0; i < n; i++) begin
         wr_valid = 1'b1;
         wr_data  = base + 16'(i);
         shadow[int'(((a + 19'(2*i)) & 19'h7FFFE) >> 1)] = wr_data;
         while (!wr_ready) @(negedge clk);
         @(negedge clk);
      end
      wr_valid = 1'b0;
   endtask

   task automatic drain_reads(input logic [18:0] a, input int n);
      for (int i = 0; i < n; i++) begin
         int idx;
         logic [15:0] want;
         logic [15:0] held;
         idx  = int'(((a + 19'(2*i)) & 19'h7FFFE) >> 1);
         want = shadow.exists(idx) ? shadow[idx] : 16'h0000;
         while (!rd_valid) @(negedge clk);
         chk("R11", "read data", rd_data, want);
         if (i == 0) begin
            held = rd_data;
            @(negedge clk);
            @(negedge clk);
            chk("R11", "valid held while stalled", rd_valid, 1);
            chk("R11", "data held while stalled", rd_data, held);
         end
         rd_ready = 1'b1;
         @(negedge clk);
         rd_ready = 1'b0;
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #1_500_000;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      int blen;
      int ops0;
      repeat (3) @(negedge clk);
      // R12: reset state, sampled while reset is held and after release
      chk("R12", "busy in reset", busy, 0);
      chk("R12", "irq_flag in reset", irq_flag, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12", "xfer_addr", xfer_addr, 0);
      chk("R12", "busy", busy, 0);
      chk("R12", "mem_dirty", mem_dirty, 0);
      chk("R12", "wr_ready", wr_ready, 0);
      chk("R12", "rd_valid", rd_valid, 0);

      // R3: address load clears bit 0
      load_addr(19'h00101);
      chk("R3", "aligned load", xfer_addr, 19'h00100);

      // Vector table: R2 R4 R5 R6 R8
      for (int v = 0; v < NV; v++) begin
         vec_t t;
         t = VECS[v];
         ack_irq();
         irq_addr_reg = t.ireg;
         irq_enable   = t.en;
         load_addr(t.a);
         fire(t.wr, t.n);
         fork
            count_busy(blen);
            begin
               if (t.wr) feed_writes(t.a, int'(t.n), 16'(16'h1000 + v * 16'h0100));
               else      drain_reads(t.a, int'(t.n));
            end
         join
         chk("R8", $sformatf("busy length vec %0d", v), blen, 20 * int'(t.n) + 1);
         chk("R4", $sformatf("end address vec %0d", v), xfer_addr, t.xend);
         chk((t.xend < t.a && t.wr) ? "R6" : "R5", $sformatf("irq vec %0d", v), irq_flag, t.xirq);
         if (t.wr) begin
            for (int i = 0; i < int'(t.n); i++) begin
               int idx;
               idx = int'(((t.a + 19'(2*i)) & 19'h7FFFE) >> 1);
               chk(t.a + 19'(2*i) < t.a ? "R3" : "R2", $sformatf("ram word vec %0d beat %0d", v, i),
                   mem.exists(idx) ? mem[idx] : 16'hxxxx, shadow[idx]);
            end
         end
         @(negedge clk);
      end

      // R7: flag stays set until acknowledged; late enable does not set it
      ack_irq();
      chk("R7", "flag cleared by ack", irq_flag, 0);
      irq_addr_reg = 16'h0020;
      irq_enable   = 1'b0;
      load_addr(19'h00100);
      fire(1'b1, 16'd1);
      irq_enable = 1'b1;
      fork
         count_busy(blen);
         feed_writes(19'h00100, 1, 16'h7777);
      join
      chk("R7", "no flag when disabled at start", irq_flag, 0);
      load_addr(19'h00100);
      fire(1'b1, 16'd1);
      fork
         count_busy(blen);
         feed_writes(19'h00100, 1, 16'h7778);
      join
      repeat (5) @(negedge clk);
      chk("R7", "flag sticky", irq_flag, 1);
      ack_irq();
      chk("R7", "flag cleared", irq_flag, 0);

      // R1: start during busy is ignored
      load_addr(19'h00400);
      wr_valid = 1'b1;
      wr_data  = 16'hBEEF;
      ops0 = ram_ops;
      fire(1'b1, 16'd1);
      blen = 0;
      while (busy && blen < 1000) begin
         if (blen == 5) begin
            count = 16'd5;
            start = 1'b1;
         end else begin
            start = 1'b0;
         end
         blen++;
         @(negedge clk);
      end
      start    = 1'b0;
      wr_valid = 1'b0;
      chk("R1", "busy not extended", blen, 21);
      chk("R1", "ram accesses", ram_ops - ops0, 1);
      chk("R1", "address after ignored start", xfer_addr, 19'h00402);
      chk("R2", "written word", mem.exists(19'h00400 >> 1) ? mem[19'h00400 >> 1] : 16'h0, 16'hBEEF);

      // R9: zero-length transfer
      irq_addr_reg = 16'h0060;
      irq_enable   = 1'b1;
      load_addr(19'h00300);
      ops0 = ram_ops;
      fire(1'b0, 16'd0);
      count_busy(blen);
      chk("R9", "busy length", blen, 1);
      chk("R9", "no ram access", ram_ops - ops0, 0);
      chk("R9", "address unchanged", xfer_addr, 19'h00300);
      chk("R9", "no irq", irq_flag, 0);

      // R10: dirty flag sources
      ack_dirty();
      chk("R10", "dirty cleared", mem_dirty, 0);
      fire(1'b0, 16'd0);
      count_busy(blen);
      chk("R10", "read leaves dirty clear", mem_dirty, 0);
      fire(1'b1, 16'd0);
      count_busy(blen);
      chk("R10", "zero-length write sets dirty", mem_dirty, 1);

      finish_run();
   end

endmodule